// File: doc/BRIEF.md
# Interrupt Flag Register with Clear-on-Read

This block collects eight hardware event sources into one status byte, masks them with a per-bit enable byte and a global enable, and raises a single interrupt request. A host reaches the status byte, the enable byte and a few configuration bytes through a plain register port. The port has separate read and write strobes, an address and data in each direction. Read data is combinational, so the value returned in a read cycle is the one held before that read has any effect.

Three flags report short-lived radio events: transmit delimiter sent, receive delimiter seen, and energy/clear-channel measurement done. These clear when the host reads the status byte. The error and warning flags stay set until the host writes them to zero. The three GPIO flags are level-qualified. A pin is synchronized through two flops. Its flag is raised only while the mode field selects normal operation, the pin is enabled, the pin is set as an input, and its level equals the programmed polarity. The battery monitor appears only as a 5-bit level input, which is compared against a programmed threshold.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset every register, flag and the measurement start bit is 0 and `irq` is low. A read returns the status byte at 0x07, the enable byte at 0x08, {global enable, 000, mode[3:0]} at 0x09, {0, polarity[2:0], 0, pin enable[2:0]} at 0x0A, {start, 0000, input select[2:0]} at 0x0B, {000, threshold[4:0]} at 0x0C, and 0 at any other address.
- R2: Status bit 7 sets after a `tx_sfd_done` cycle, bit 6 after `rx_sfd_seen`, bit 5 after `err_evt`, and bit 3 after `meas_done`. Each sets at the rising edge that samples its event.
- R3: A read of 0x07 returns the current flags and clears bits 7, 6 and 3 at that edge.
- R4: A hardware set event for a bit wins over a clear-on-read and over a host write of 0 to that bit in the same cycle.
- R5: Bits 5 (error) and 4 (warning) are not cleared by reads; only a host write of 0 clears them.
- R6: A host write to 0x07 loads all eight flags from `wdata`, with hardware set events ORed in. A write takes priority over a read in the same cycle.
- R7: GPIO flag i (status bit i, i = 0..2) sets on an edge only when the mode field equals 0 (normal), pin enable bit i is 1, input select bit i is 1, and the synchronized pin level equals polarity bit i.
- R8: A pin level presented before rising edge k reaches the GPIO compare through two flops, so its flag is first visible after edge k+2.
- R9: The warning flag (bit 4) sets on every edge where `bat_level` is below the threshold, or where `res_missing` is high.
- R10: `irq` is high exactly when the global enable (0x09 bit 7) is 1 and at least one status bit is 1 with its enable bit (same position at 0x08) also 1, with no register delay.
- R11: The measurement start bit (0x0B bit 7, also on `meas_start`) is set by a host write and cleared at the edge that samples `meas_done`. The clear wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational |
| tx_sfd_done | input | 1 | Last delimiter sample transmitted |
| rx_sfd_seen | input | 1 | Receive delimiter detected |
| err_evt | input | 1 | Malfunction detected |
| bat_level | input | 5 | Battery comparator level code |
| res_missing | input | 1 | External resistor missing indication |
| meas_done | input | 1 | Energy/clear-channel measurement complete |
| gpio_in | input | 3 | Asynchronous GPIO pin levels |
| meas_start | output | 1 | Measurement start bit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a hardware event landing in the very cycle the host reads or writes the status byte. That collision decides whether an event is lost. Directed steps place a delimiter event on the read edge and on a write of zero, and then read again. The random phase fires events and host accesses independently on every cycle, so these collisions recur many times. GPIO qualification is also reached with effort, because it needs four configuration fields to line up with a pin level that arrives two cycles late. The random writes bias the mode field toward normal and step the pins so that matches occur.

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_STATUS = 'h07,
  parameter logic [AW-1:0] ADDR_EN     = 'h08,
  parameter logic [AW-1:0] ADDR_CTRL   = 'h09,
  parameter logic [AW-1:0] ADDR_GPIO   = 'h0A,
  parameter logic [AW-1:0] ADDR_DIR    = 'h0B,
  parameter logic [AW-1:0] ADDR_BAT    = 'h0C,
  parameter logic [3:0]    MODE_NORMAL = 4'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          tx_sfd_done,
  input  logic          rx_sfd_seen,
  input  logic          err_evt,
  input  logic [4:0]    bat_level,
  input  logic          res_missing,
  input  logic          meas_done,
  input  logic [2:0]    gpio_in,
  output logic          meas_start,
  output logic          irq
);

  localparam logic [7:0] SELF_CLR = 8'hC8;

  logic [7:0] flags, en;
  logic       gie;
  logic [3:0] mode;
  logic [2:0] gen, pol, dir;
  logic [4:0] thr;
  logic [2:0] s1, s2;

  logic       wr_stat, rd_stat, warn;
  logic [2:0] gpio_hit;
  logic [7:0] hw_set, flags_base;

  assign wr_stat  = wr_en && addr == ADDR_STATUS;
  assign rd_stat  = rd_en && addr == ADDR_STATUS;
  assign warn     = (bat_level < thr) | res_missing;
  assign gpio_hit = (mode == MODE_NORMAL) ? (gen & dir & ~(s2 ^ pol)) : 3'b000;
  assign hw_set   = {tx_sfd_done, rx_sfd_seen, err_evt, warn, meas_done, gpio_hit};
  assign flags_base = wr_stat ? wdata : (rd_stat ? (flags & ~SELF_CLR) : flags);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gpio_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_base | hw_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= '0;
      gie  <= 1'b0;
      mode <= '0;
      gen  <= '0;
      pol  <= '0;
      dir  <= '0;
      thr  <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_EN:   en <= wdata;
        ADDR_CTRL: begin
          gie  <= wdata[7];
          mode <= wdata[3:0];
        end
        ADDR_GPIO: begin
          gen <= wdata[2:0];
          pol <= wdata[6:4];
        end
        ADDR_DIR:  dir <= wdata[2:0];
        ADDR_BAT:  thr <= wdata[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          meas_start <= 1'b0;
    else if (meas_done)                  meas_start <= 1'b0;
    else if (wr_en && addr == ADDR_DIR)  meas_start <= wdata[7];
  end

  always_comb begin
    case (addr)
      ADDR_STATUS: rdata = flags;
      ADDR_EN:     rdata = en;
      ADDR_CTRL:   rdata = {gie, 3'b000, mode};
      ADDR_GPIO:   rdata = {1'b0, pol, 1'b0, gen};
      ADDR_DIR:    rdata = {meas_start, 4'b0000, dir};
      ADDR_BAT:    rdata = {3'b000, thr};
      default:     rdata = 8'h00;
    endcase
  end

  assign irq = gie & |(flags & en);

endmodule

module irq_flag_reg_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_STATUS = 'h07,
  parameter logic [3:0]    MODE_NORMAL = 4'h0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    flags,
  input logic [7:0]    en,
  input logic          gie,
  input logic [3:0]    mode,
  input logic          irq,
  input logic          tx_sfd_done,
  input logic          meas_done,
  input logic          meas_start
);

  a_r3_tx_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == ADDR_STATUS && !wr_en && !tx_sfd_done |=> !flags[7]);

  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sfd_done |=> flags[7]);

  a_r5_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flags[5] && !(wr_en && addr == ADDR_STATUS) |=> flags[5]);

  a_r7_gpio_needs_normal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) && !$past(wr_en && addr == ADDR_STATUS) |-> $past(mode) == MODE_NORMAL);

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie || (flags & en) == 8'h00) |-> !irq);

  a_r11_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_start);

endmodule

bind irq_flag_reg irq_flag_reg_chk #(
  .AW(AW), .ADDR_STATUS(ADDR_STATUS), .MODE_NORMAL(MODE_NORMAL)
) chk_i (.*);

// File: tb/irq_flag_reg_tb.sv
`timescale 1ns/1ps
module irq_flag_reg_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic tx_sfd_done = 0, rx_sfd_seen = 0, err_evt = 0, res_missing = 0, meas_done = 0;
  logic [4:0] bat_level = 0;
  logic [2:0] gpio_in = 0;
  logic meas_start, irq;

  always #2.5 clk = ~clk;

  irq_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_sfd_done(tx_sfd_done), .rx_sfd_seen(rx_sfd_seen),
    .err_evt(err_evt), .bat_level(bat_level), .res_missing(res_missing),
    .meas_done(meas_done), .gpio_in(gpio_in), .meas_start(meas_start), .irq(irq)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic e_tx = 0, e_rx = 0, e_err = 0, e_meas = 0;
  logic g_res = 0;
  logic [4:0] g_bat = 0;
  logic [2:0] g_gpio = 0;
  logic [7:0] rd_val;

  logic [7:0] m_flags = 0, m_en = 0;
  logic m_gie = 0, m_start = 0;
  logic [3:0] m_mode = 0;
  logic [2:0] m_gen = 0, m_pol = 0, m_dir = 0, m_s1 = 0, m_s2 = 0;
  logic [4:0] m_thr = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h07: return m_flags;
      8'h08: return m_en;
      8'h09: return {m_gie, 3'b000, m_mode};
      8'h0A: return {1'b0, m_pol, 1'b0, m_gen};
      8'h0B: return {m_start, 4'b0000, m_dir};
      8'h0C: return {3'b000, m_thr};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic m_irq();
    return m_gie & |(m_flags & m_en);
  endfunction

  // op: 0 idle, 1 read, 2 write
  task automatic step(input int op, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] base, setv;
    logic [2:0] q;
    logic w;
    rd_en = (op == 1); wr_en = (op == 2); addr = a; wdata = d;
    tx_sfd_done = e_tx; rx_sfd_seen = e_rx; err_evt = e_err; meas_done = e_meas;
    bat_level = g_bat; res_missing = g_res; gpio_in = g_gpio;
    #1;
    rd_val = rdata;
    if (op == 1) chk("R1 read data", rdata, m_read(a));
    chk("R10 irq", {7'b0, irq}, {7'b0, m_irq()});
    chk("R11 start", {7'b0, meas_start}, {7'b0, m_start});
    q = (m_mode == 4'h0) ? (m_gen & m_dir & ~(m_s2 ^ m_pol)) : 3'b000;
    w = (g_bat < m_thr) | g_res;
    setv = {e_tx, e_rx, e_err, w, e_meas, q};
    if (op == 2 && a == 8'h07) base = d;
    else if (op == 1 && a == 8'h07) base = m_flags & 8'h37;
    else base = m_flags;
    m_flags = base | setv;
    if (e_meas) m_start = 0;
    else if (op == 2 && a == 8'h0B) m_start = d[7];
    if (op == 2) begin
      case (a)
        8'h08: m_en = d;
        8'h09: begin m_gie = d[7]; m_mode = d[3:0]; end
        8'h0A: begin m_gen = d[2:0]; m_pol = d[6:4]; end
        8'h0B: m_dir = d[2:0];
        8'h0C: m_thr = d[4:0];
        default: ;
      endcase
    end
    m_s2 = m_s1; m_s1 = g_gpio;
    @(posedge clk); @(negedge clk);
    e_tx = 0; e_rx = 0; e_err = 0; e_meas = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    step(1, 8'h07, 0); chk("R1 reset status", rd_val, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    step(1, 8'h3F, 0); chk("R1 unmapped", rd_val, 8'h00);

    e_tx = 1; step(0, 0, 0);
    step(1, 8'h07, 0); chk("R2 tx flag", rd_val, 8'h80);
    step(1, 8'h07, 0); chk("R3 cleared by read", rd_val, 8'h00);

    e_rx = 1; step(1, 8'h07, 0); chk("R4 read value before set", rd_val, 8'h00);
    step(1, 8'h07, 0); chk("R4 set beats read clear", rd_val, 8'h40);
    e_tx = 1; step(2, 8'h07, 8'h00);
    step(1, 8'h07, 0); chk("R4 set beats write zero", rd_val, 8'h80);

    e_err = 1; step(0, 0, 0);
    step(1, 8'h07, 0); chk("R5 error set", rd_val, 8'h20);
    step(1, 8'h07, 0); chk("R5 error sticky", rd_val, 8'h20);
    step(2, 8'h07, 8'h00);
    step(1, 8'h07, 0); chk("R5 error cleared by write", rd_val, 8'h00);

    step(2, 8'h07, 8'hFF);
    step(1, 8'h07, 0); chk("R6 write all ones", rd_val, 8'hFF);
    step(1, 8'h07, 0); chk("R6 R3 only self-clearing bits drop", rd_val, 8'h37);
    step(2, 8'h07, 8'h00);

    step(2, 8'h0C, 8'd10);
    g_bat = 5; step(0, 0, 0);
    step(1, 8'h07, 0); chk("R9 battery below threshold", rd_val, 8'h10);
    g_bat = 20; step(2, 8'h07, 8'h00);
    step(1, 8'h07, 0); chk("R9 battery above threshold", rd_val, 8'h00);
    g_res = 1; step(0, 0, 0); g_res = 0;
    step(1, 8'h07, 0); chk("R9 resistor missing", rd_val, 8'h10);
    step(2, 8'h07, 8'h00);

    step(2, 8'h09, 8'h00); step(2, 8'h0A, 8'h11); step(2, 8'h0B, 8'h01);
    g_gpio = 3'b001; step(0, 0, 0); step(0, 0, 0);
    step(1, 8'h07, 0); chk("R8 not yet through synchronizer", rd_val, 8'h00);
    step(1, 8'h07, 0); chk("R7 R8 gpio0 qualified", rd_val, 8'h01);
    g_gpio = 0; repeat (4) step(0, 0, 0);
    step(2, 8'h07, 8'h00);
    step(1, 8'h07, 0); chk("R7 polarity mismatch", rd_val, 8'h00);
    step(2, 8'h09, 8'h05); g_gpio = 3'b001; repeat (4) step(0, 0, 0);
    step(1, 8'h07, 0); chk("R7 mode not normal", rd_val, 8'h00);
    step(2, 8'h0B, 8'h00); step(2, 8'h09, 8'h00); repeat (4) step(0, 0, 0);
    step(1, 8'h07, 0); chk("R7 pin not input", rd_val, 8'h00);
    g_gpio = 0; step(2, 8'h0A, 8'h00);

    step(2, 8'h08, 8'h20); step(2, 8'h09, 8'h80);
    e_err = 1; step(0, 0, 0);
    chk("R10 irq raised", {7'b0, irq}, 8'h01);
    step(2, 8'h09, 8'h00); chk("R10 global enable off", {7'b0, irq}, 8'h00);
    step(2, 8'h09, 8'h80); step(2, 8'h08, 8'h00);
    chk("R10 bit enable off", {7'b0, irq}, 8'h00);
    step(2, 8'h07, 8'h00); step(2, 8'h09, 8'h00);

    step(2, 8'h0B, 8'h80); chk("R11 start set", {7'b0, meas_start}, 8'h01);
    e_meas = 1; step(0, 0, 0); chk("R11 start cleared", {7'b0, meas_start}, 8'h00);
    step(1, 8'h07, 0); chk("R2 measurement flag", rd_val, 8'h08);
    e_meas = 1; step(2, 8'h0B, 8'h80);
    chk("R11 done beats write", {7'b0, meas_start}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a, d;
      int op, r;
      e_tx = ($urandom % 12) == 0;
      e_rx = ($urandom % 12) == 0;
      e_meas = ($urandom % 12) == 0;
      e_err = ($urandom % 64) == 0;
      if (($urandom % 64) == 0) g_res = ~g_res;
      if (($urandom % 32) == 0) g_bat = 5'($urandom);
      if (($urandom % 4) == 0) g_gpio = 3'($urandom);
      r = $urandom % 7;
      case (r)
        0: a = 8'h07; 1: a = 8'h08; 2: a = 8'h09; 3: a = 8'h0A;
        4: a = 8'h0B; 5: a = 8'h0C; default: a = 8'h3F;
      endcase
      d = 8'($urandom);
      if (a == 8'h09 && ($urandom % 2) == 0) d[3:0] = 4'h0;
      if (a == 8'h0C) d[4:0] = 5'($urandom % 12);
      op = $urandom % 10;
      if (op < 4) step(1, 8'h07, 0);
      else if (op < 5) step(1, a, 0);
      else if (op < 7) step(2, a, d);
      else step(0, 0, 0);
    end

    finish_run();
  end

endmodule